// File: doc/BRIEF.md
# Conditional Trap Comparator

This block decides whether a conditional trap instruction fires. It takes two operands and a 5-bit condition mask. It evaluates five relations between the operands at the same time: signed less, signed greater, equal, unsigned less and unsigned greater. Each mask bit enables one relation. If any enabled relation holds, the block requests a program trap and attaches a fixed trap subcode, which the exception logic uses to tell this trap apart from other program-check causes.

An operand-width select picks one of two modes. Word mode compares only the low 32 bits of each operand, read as signed or unsigned as each relation needs. Doubleword mode compares the full 64 bits. Decoding the instruction and entering the exception are handled elsewhere.

Operations enter through a valid/ready handshake and are registered. Each verdict leaves through a second valid/ready handshake one cycle after it was accepted. The output stage holds a single verdict. A new operation is accepted only when the stage is empty or its verdict is being taken in the same cycle. While the consumer holds `res_ready` low, `in_ready` is low and the held verdict does not change.

Top module: `trap_comparator`

## Requirements
- R1: Mask bit 4 (value 0x10) enables the signed less-than relation (first operand below second).
- R2: Mask bit 3 (value 0x08) enables the signed greater-than relation.
- R3: Mask bit 2 (value 0x04) enables the equality relation.
- R4: Mask bit 1 (value 0x02) enables unsigned less-than, and mask bit 0 (value 0x01) enables unsigned greater-than.
- R5: When `in_word` is 1, only bits 31:0 of each operand take part, and bits 63:32 have no effect on the verdict. When `in_word` is 0, all 64 bits are compared.
- R6: `res_trap` is the OR over all enabled relations. `res_code` equals the parameter TRAP_CODE (default 3) when `res_trap` is 1, and 0 otherwise.
- R7: A mask of 0x00 never traps, and a mask of 0x1F always traps, whatever the operands.
- R8: An operation accepted on a clock edge (`in_valid` and `in_ready` both high) shows `res_valid` high after that edge. A verdict taken with `res_ready` high, with no new operation accepted on that edge, leaves `res_valid` low.
- R9: While `res_valid` is high and `res_ready` is low, `in_ready` is low, and `res_valid`, `res_trap` and `res_code` keep their values.
- R10: After reset, `res_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_opa | input | 64 | First operand |
| in_opb | input | 64 | Second operand |
| in_mask | input | 5 | Relation enable mask |
| in_word | input | 1 | 1 selects the 32-bit compare, 0 the 64-bit compare |
| res_valid | output | 1 | Verdict available |
| res_ready | input | 1 | Consumer takes the verdict |
| res_trap | output | 1 | Trap requested |
| res_code | output | 4 | Trap subcode, 0 when no trap |

## Verification
Two functions can fall in the same cycle: draining a held verdict and accepting the next operation. The bench provokes this by streaming operations back to back with `res_ready` held high. It also stalls the consumer with a second operation waiting, then releases it, so the held verdict leaves on the same edge that the waiting operation enters. The verdict read on the next cycle must be the one computed for the waiting operation. The verdict read during the stall must still be the first one, unchanged.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;
  // Relation slots; a slot index equals the mask bit that enables it.
  localparam int REL_N   = 5;
  localparam int REL_UGT = 0;
  localparam int REL_ULT = 1;
  localparam int REL_EQ  = 2;
  localparam int REL_SGT = 3;
  localparam int REL_SLT = 4;

  typedef logic [REL_N-1:0] rel_vec_t;
endpackage

// File: rtl/trap_operand_prep.sv
module trap_operand_prep #(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32
) (
  input  logic [XLEN-1:0] raw,
  input  logic            word,
  output logic [XLEN:0]   sx,   // signed view, one guard bit
  output logic [XLEN:0]   zx    // unsigned view, guard bit zero
);
  localparam int EXT_W = XLEN + 1 - WORD_W;

  generate
    if (WORD_W < XLEN) begin : g_two_widths
      always_comb begin
        if (word) begin
          sx = {{EXT_W{raw[WORD_W-1]}}, raw[WORD_W-1:0]};
          zx = {{EXT_W{1'b0}}, raw[WORD_W-1:0]};
        end else begin
          sx = {raw[XLEN-1], raw};
          zx = {1'b0, raw};
        end
      end
    end else begin : g_one_width
      logic unused_word;
      assign unused_word = word;
      assign sx = {raw[XLEN-1], raw};
      assign zx = {1'b0, raw};
    end
  endgenerate
endmodule

// File: rtl/trap_relation_eval.sv
module trap_relation_eval
  import trap_cmp_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN:0]  a_sx,
  input  logic [XLEN:0]  a_zx,
  input  logic [XLEN:0]  b_sx,
  input  logic [XLEN:0]  b_zx,
  input  rel_vec_t       mask,
  output rel_vec_t       rel,
  output logic           hit
);
  rel_vec_t gated;

  // Guard bit lets every relation use a single signed comparator form.
  always_comb begin
    rel          = '0;
    rel[REL_SLT] = $signed(a_sx) < $signed(b_sx);
    rel[REL_SGT] = $signed(a_sx) > $signed(b_sx);
    rel[REL_EQ]  = a_zx == b_zx;
    rel[REL_ULT] = $signed(a_zx) < $signed(b_zx);
    rel[REL_UGT] = $signed(a_zx) > $signed(b_zx);
  end

  genvar gi;
  generate
    for (gi = 0; gi < REL_N; gi++) begin : g_gate
      assign gated[gi] = rel[gi] & mask[gi];
    end
  endgenerate

  assign hit = |gated;
endmodule

// File: rtl/trap_result_stage.sv
module trap_result_stage #(
  parameter int              CODE_W    = 4,
  parameter logic [CODE_W-1:0] TRAP_CODE = 4'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              hit,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_trap,
  output logic [CODE_W-1:0] res_code
);
  logic take;

  assign in_ready = !res_valid || res_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_trap  <= 1'b0;
      res_code  <= '0;
    end else if (take) begin
      res_valid <= 1'b1;
      res_trap  <= hit;
      res_code  <= hit ? TRAP_CODE : '0;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/trap_comparator.sv
module trap_comparator
  import trap_cmp_pkg::*;
#(
  parameter int                XLEN      = 64,
  parameter int                WORD_W    = 32,
  parameter int                CODE_W    = 4,
  parameter logic [CODE_W-1:0] TRAP_CODE = 4'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [XLEN-1:0]   in_opa,
  input  logic [XLEN-1:0]   in_opb,
  input  logic [REL_N-1:0]  in_mask,
  input  logic              in_word,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_trap,
  output logic [CODE_W-1:0] res_code
);
  logic [XLEN:0] a_sx, a_zx, b_sx, b_zx;
  rel_vec_t      rel;
  logic          hit;

  trap_operand_prep #(.XLEN(XLEN), .WORD_W(WORD_W)) u_prep_a (
    .raw(in_opa), .word(in_word), .sx(a_sx), .zx(a_zx));
  trap_operand_prep #(.XLEN(XLEN), .WORD_W(WORD_W)) u_prep_b (
    .raw(in_opb), .word(in_word), .sx(b_sx), .zx(b_zx));

  trap_relation_eval #(.XLEN(XLEN)) u_eval (
    .a_sx(a_sx), .a_zx(a_zx), .b_sx(b_sx), .b_zx(b_zx),
    .mask(in_mask), .rel(rel), .hit(hit));

  trap_result_stage #(.CODE_W(CODE_W), .TRAP_CODE(TRAP_CODE)) u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .hit(hit), .res_valid(res_valid), .res_ready(res_ready),
    .res_trap(res_trap), .res_code(res_code));

  logic unused_rel;
  assign unused_rel = ^rel;
endmodule

// File: rtl/trap_comparator_chk.sv
module trap_comparator_chk #(
  parameter int                CODE_W    = 4,
  parameter logic [CODE_W-1:0] TRAP_CODE = 4'd3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [4:0]        in_mask,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_trap,
  input logic [CODE_W-1:0] res_code
);
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> res_valid);

  a_r8_drain: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready && !in_valid |=> !res_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_trap) && $stable(res_code));

  a_r7_never: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_mask == 5'h00 |=> !res_trap);

  a_r7_always: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_mask == 5'h1F |=> res_trap);

  a_r6_code: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_code == (res_trap ? TRAP_CODE : '0)));
endmodule

bind trap_comparator trap_comparator_chk #(.CODE_W(CODE_W), .TRAP_CODE(TRAP_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_mask(in_mask), .res_valid(res_valid), .res_ready(res_ready),
  .res_trap(res_trap), .res_code(res_code));

// File: tb/trap_comparator_test.sv
module trap_comparator_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] CODE = 4'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_opa = '0, in_opb = '0;
  logic [4:0]  in_mask = '0;
  logic        in_word = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_trap;
  logic [3:0]  res_code;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_comparator uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opa(in_opa), .in_opb(in_opb), .in_mask(in_mask), .in_word(in_word),
    .res_valid(res_valid), .res_ready(res_ready), .res_trap(res_trap),
    .res_code(res_code));

  function automatic logic model(logic [63:0] a, logic [63:0] b, logic [4:0] m, logic w);
    logic slt, sgt, eq, ult, ugt;
    if (w) begin
      slt = $signed(a[31:0]) < $signed(b[31:0]);
      sgt = $signed(a[31:0]) > $signed(b[31:0]);
      eq  = a[31:0] == b[31:0];
      ult = a[31:0] < b[31:0];
      ugt = a[31:0] > b[31:0];
    end else begin
      slt = $signed(a) < $signed(b);
      sgt = $signed(a) > $signed(b);
      eq  = a == b;
      ult = a < b;
      ugt = a > b;
    end
    return (m[4] & slt) | (m[3] & sgt) | (m[2] & eq) | (m[1] & ult) | (m[0] & ugt);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_verdict(string req, logic exp);
    check(res_valid === 1'b1, {req, " valid"}, res_valid, 1);
    check(res_trap === exp, {req, " trap"}, res_trap, exp);
    check(res_code === (exp ? CODE : 4'd0), {req, " code (R6)"}, res_code, exp ? CODE : 0);
  endtask

  // Presents one operation at a negedge, reads its verdict at the next negedge.
  task automatic run_op(string req, logic [63:0] a, logic [63:0] b, logic [4:0] m, logic w);
    in_valid = 1'b1; in_opa = a; in_opb = b; in_mask = m; in_word = w;
    res_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_verdict(req, model(a, b, m, w));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(res_valid === 1'b0, "R10 reset valid", res_valid, 0);
    check(in_ready === 1'b1, "R10 reset ready", in_ready, 1);

    // R1..R4 single relations
    run_op("R1 slt", 64'hFFFF_FFFF_FFFF_FFFE, 64'd1, 5'h10, 1'b0);
    run_op("R1 slt false", 64'd5, 64'd1, 5'h10, 1'b0);
    run_op("R2 sgt", 64'd1, 64'hFFFF_FFFF_FFFF_FFFE, 5'h08, 1'b0);
    run_op("R3 eq", 64'h1234, 64'h1234, 5'h04, 1'b0);
    run_op("R3 eq false", 64'h1234, 64'h1235, 5'h04, 1'b0);
    run_op("R4 ult", 64'd1, 64'hFFFF_FFFF_FFFF_FFFE, 5'h02, 1'b0);
    run_op("R4 ugt", 64'hFFFF_FFFF_FFFF_FFFE, 64'd1, 5'h01, 1'b0);
    run_op("R4 ugt false", 64'd1, 64'hFFFF_FFFF_FFFF_FFFE, 5'h01, 1'b0);
    // R5 upper halves ignored in word mode
    run_op("R5 eq word", 64'hFFFF_0000_0000_0005, 64'h0000_0000_0000_0005, 5'h04, 1'b1);
    run_op("R5 eq dword", 64'hFFFF_0000_0000_0005, 64'h0000_0000_0000_0005, 5'h04, 1'b0);
    run_op("R5 slt word", 64'h0000_0000_8000_0000, 64'd1, 5'h10, 1'b1);
    run_op("R5 slt dword", 64'h0000_0000_8000_0000, 64'd1, 5'h10, 1'b0);
    run_op("R5 ugt word", 64'h0000_0000_8000_0000, 64'h7777_0000_0000_0001, 5'h01, 1'b1);
    // R7 mask extremes
    run_op("R7 zero mask", 64'd7, 64'd9, 5'h00, 1'b0);
    run_op("R7 full mask", 64'd7, 64'd9, 5'h1F, 1'b1);
    run_op("R7 full mask eq", 64'd9, 64'd9, 5'h1F, 1'b0);

    // R8 drain without new input
    @(negedge clk);
    check(res_valid === 1'b0, "R8 drained", res_valid, 0);

    // R9 stall with a waiting op, then simultaneous drain and accept
    in_valid = 1'b1; in_opa = 64'd3; in_opb = 64'd3; in_mask = 5'h1F; in_word = 1'b0;
    @(negedge clk);
    res_ready = 1'b0;
    in_opa = 64'd4; in_opb = 64'd8; in_mask = 5'h00;
    @(negedge clk);
    check(in_ready === 1'b0, "R9 stall ready", in_ready, 0);
    check_verdict("R9 held first", 1'b1);
    @(negedge clk);
    check_verdict("R9 still held", 1'b1);
    res_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_verdict("R8 waiting op after release", 1'b0);
    @(negedge clk);
    check(res_valid === 1'b0, "R8 idle after release", res_valid, 0);

    // Random streaming, R6 OR of enabled relations
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      logic [4:0] m;
      logic w;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      case ($urandom_range(0, 3))
        0: b = a;
        1: b[31:0] = a[31:0];
        2: b = a + 64'd1;
        default: ;
      endcase
      m = 5'($urandom);
      w = 1'($urandom);
      run_op("R6 random", a, b, m, w);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule